// File: doc/BRIEF.md
# Microsecond Timer with Coherent Split Readout

This block is a 12-bit up-counter that runs freely at one count per microsecond, so it can measure intervals of up to roughly 4 ms before it wraps. A parameterized divider turns the system clock into a one-per-microsecond enable. An input gates that divider, which lets the counter be paused. Two periodic interrupt requests come out as single-cycle pulses. The short one fires every 128 counts and the long one every 1024 counts.

A processor reads the value as two bytes. A read of the low-byte address returns counter bits 7..0 and, on the same access, copies counter bits 11..8 into a holding register. A read of the high-byte address returns that holding register and not the live counter. The two halves therefore always belong to the same instant, however much time passes between the two reads.

Top module: `usec_timer12`

## Requirements
- R1: After reset the counter, the holding register, the read data output and both interrupt outputs are 0.
- R2: While `tick_en_i` is high the counter increments by one every `CLK_PER_US` clock cycles.
- R3: While `tick_en_i` is low neither the counter nor the divider advances.
- R4: A strobed read at address 0x24 returns counter bits 7..0, as they stood in the strobe cycle, on `rd_data_o` from the next cycle.
- R5: A strobed read at address 0x24 loads counter bits 11..8 into the holding register. A strobed read at 0x25 returns that register in bits 3..0, with bits 7..4 equal to 0.
- R6: The holding register changes only on a strobed read at 0x24. It keeps its value while the counter advances.
- R7: `irq_fast_o` is high for exactly one clock cycle each time counter bit 6 falls, which is each time the counter reaches a multiple of 128.
- R8: `irq_slow_o` is high for exactly one clock cycle each time counter bit 9 falls, which is each time the counter reaches a multiple of 1024. It always coincides with an `irq_fast_o` pulse.
- R9: The counter wraps from 0xFFF to 0x000 and keeps counting, with no signal other than the two interrupt pulses.
- R10: A strobed read at any other address returns 0. With `rd_stb_i` low, `rd_data_o` and the holding register keep their values whatever `rd_addr_i` does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_en_i | input | 1 | Enables the microsecond divider and so the counter |
| rd_stb_i | input | 1 | Read strobe, one cycle per access |
| rd_addr_i | input | 8 | Read address |
| rd_data_o | output | 8 | Registered read data, held until the next strobe |
| irq_fast_o | output | 1 | One-cycle pulse every 128 counts |
| irq_slow_o | output | 1 | One-cycle pulse every 1024 counts |

## Verification
The checker assumes that `rd_stb_i` and `rd_addr_i` are settled at every rising edge. It also assumes that reads, pauses and resumes are arbitrary, with no protocol between them. The bench drives every input on the falling edge, so nothing changes near a sampling edge. It keeps `tick_en_i` low through reset so that the divider starts from zero. The bench builds the design with a two-cycle divider so that a full wrap of the counter fits in a short run. The divider rule itself is unchanged by that choice.

// File: rtl/timer12_pkg.sv
package timer12_pkg;
  localparam int CNT_W     = 12;
  localparam int DATA_W    = 8;
  localparam int NIB_W     = CNT_W - DATA_W;
  localparam int FAST_BIT  = 6;
  localparam int SLOW_BIT  = 9;
  localparam logic [7:0] ADDR_LO = 8'h24;
  localparam logic [7:0] ADDR_HI = 8'h25;

  typedef logic [CNT_W-1:0]  cnt_t;
  typedef logic [DATA_W-1:0] byte_t;
  typedef logic [NIB_W-1:0]  nib_t;
endpackage

// File: rtl/usec_prescaler.sv
module usec_prescaler #(
  parameter int DIV = 250
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pre_q, pre_d;
  logic          at_last;

  assign at_last = (pre_q == LAST);
  assign tick_o  = en_i & at_last;

  always_comb begin
    pre_d = pre_q;
    if (en_i) pre_d = at_last ? '0 : pre_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pre_q <= '0;
    else         pre_q <= pre_d;
  end
endmodule

// File: rtl/timer_core.sv
module timer_core
  import timer12_pkg::*;
#(
  parameter int W     = CNT_W,
  parameter int BIT_A = FAST_BIT,
  parameter int BIT_B = SLOW_BIT
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  output logic [W-1:0] cnt_o,
  output logic [1:0]   irq_o
);
  localparam int NIRQ = 2;
  localparam int IRQ_BIT [NIRQ] = '{BIT_A, BIT_B};

  logic [W-1:0]    cnt_q, cnt_d;
  logic [NIRQ-1:0] irq_q, irq_d;

  always_comb begin
    cnt_d = cnt_q;
    if (tick_i) cnt_d = cnt_q + 1'b1;
  end

  // a bit falls on increment exactly when it and every bit below it are 1
  genvar g;
  generate
    for (g = 0; g < NIRQ; g++) begin : g_irq
      assign irq_d[g] = tick_i & (&cnt_q[IRQ_BIT[g]:0]);
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      irq_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      irq_q <= irq_d;
    end
  end

  assign cnt_o = cnt_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/read_port.sv
module read_port
  import timer12_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  rd_stb_i,
  input  byte_t rd_addr_i,
  input  cnt_t  cnt_i,
  output byte_t rd_data_o,
  output nib_t  shadow_o
);
  byte_t data_q, data_d;
  nib_t  shadow_q, shadow_d;
  logic  hit_lo, hit_hi;

  assign hit_lo = rd_stb_i & (rd_addr_i == ADDR_LO);
  assign hit_hi = rd_stb_i & (rd_addr_i == ADDR_HI);

  always_comb begin
    shadow_d = shadow_q;
    data_d   = data_q;
    if (hit_lo) shadow_d = cnt_i[CNT_W-1:DATA_W];
    if (rd_stb_i) begin
      if (hit_lo)      data_d = cnt_i[DATA_W-1:0];
      else if (hit_hi) data_d = {{(DATA_W-NIB_W){1'b0}}, shadow_q};
      else             data_d = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q   <= '0;
      shadow_q <= '0;
    end else begin
      data_q   <= data_d;
      shadow_q <= shadow_d;
    end
  end

  assign rd_data_o = data_q;
  assign shadow_o  = shadow_q;
endmodule

// File: rtl/usec_timer12.sv
module usec_timer12
  import timer12_pkg::*;
#(
  parameter int CLK_PER_US = 250
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_en_i,
  input  logic       rd_stb_i,
  input  logic [7:0] rd_addr_i,
  output logic [7:0] rd_data_o,
  output logic       irq_fast_o,
  output logic       irq_slow_o
);
  logic [1:0] rst_sync_q;
  logic       rst_n;
  logic       tick;
  cnt_t       cnt;
  nib_t       shadow;
  logic [1:0] irq;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  usec_prescaler #(.DIV(CLK_PER_US)) u_pre (
    .clk_i (clk_i), .rst_ni(rst_n), .en_i(tick_en_i), .tick_o(tick)
  );

  timer_core #(.W(CNT_W), .BIT_A(FAST_BIT), .BIT_B(SLOW_BIT)) u_core (
    .clk_i(clk_i), .rst_ni(rst_n), .tick_i(tick), .cnt_o(cnt), .irq_o(irq)
  );

  read_port u_rd (
    .clk_i(clk_i), .rst_ni(rst_n), .rd_stb_i(rd_stb_i), .rd_addr_i(rd_addr_i),
    .cnt_i(cnt), .rd_data_o(rd_data_o), .shadow_o(shadow)
  );

  assign irq_fast_o = irq[0];
  assign irq_slow_o = irq[1];
endmodule

// File: rtl/usec_timer12_chk.sv
module usec_timer12_chk
  import timer12_pkg::*;
(
  input logic       clk_i,
  input logic       rst_n,
  input logic       tick_en_i,
  input logic       tick,
  input logic       rd_stb_i,
  input logic [7:0] rd_addr_i,
  input logic [7:0] rd_data_o,
  input cnt_t       cnt,
  input nib_t       shadow,
  input logic       irq_fast_o,
  input logic       irq_slow_o
);
  assert_advance_R2: assert property (@(posedge clk_i) disable iff (!rst_n)
    tick |=> cnt == $past(cnt) + 1'b1);

  assert_pause_R3: assert property (@(posedge clk_i) disable iff (!rst_n)
    !tick_en_i |=> $stable(cnt));

  assert_hi_upper_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_n)
    (rd_stb_i && rd_addr_i == ADDR_HI) |=> rd_data_o[7:4] == 4'h0);

  assert_shadow_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_n)
    !(rd_stb_i && rd_addr_i == ADDR_LO) |=> $stable(shadow));

  assert_fast_single_R7: assert property (@(posedge clk_i) disable iff (!rst_n)
    irq_fast_o |=> !irq_fast_o);

  assert_slow_single_R8: assert property (@(posedge clk_i) disable iff (!rst_n)
    irq_slow_o |=> !irq_slow_o);

  assert_slow_with_fast_R8: assert property (@(posedge clk_i) disable iff (!rst_n)
    irq_slow_o |-> irq_fast_o);

  assert_wrap_R9: assert property (@(posedge clk_i) disable iff (!rst_n)
    (tick && cnt == 12'hFFF) |=> cnt == 12'h000);

  assert_idle_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_n)
    !rd_stb_i |=> $stable(rd_data_o));
endmodule

bind usec_timer12 usec_timer12_chk u_chk (
  .clk_i(clk_i), .rst_n(rst_n), .tick_en_i(tick_en_i), .tick(tick),
  .rd_stb_i(rd_stb_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
  .cnt(cnt), .shadow(shadow), .irq_fast_o(irq_fast_o), .irq_slow_o(irq_slow_o)
);

// File: tb/usec_timer12_test.sv
module usec_timer12_test;
  localparam int DIV = 2;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick_en;
  logic       rd_stb;
  logic [7:0] rd_addr;
  logic [7:0] rd_data;
  logic       irq_fast, irq_slow;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;

  usec_timer12 #(.CLK_PER_US(DIV)) uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_en_i(tick_en), .rd_stb_i(rd_stb),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .irq_fast_o(irq_fast),
    .irq_slow_o(irq_slow)
  );

  // reference model built from R2, R3, R9
  logic [11:0] m_cnt = '0;
  int          m_pre = 0;
  logic [3:0]  m_shadow = '0;
  int exp_fast = 0, exp_slow = 0, got_fast = 0, got_slow = 0;

  always @(posedge clk) begin
    if (tick_en) begin
      if (m_pre == DIV - 1) begin
        m_pre <= 0;
        m_cnt <= m_cnt + 12'd1;
        if (m_cnt[6:0] == 7'h7F) exp_fast <= exp_fast + 1;
        if (m_cnt[9:0] == 10'h3FF) exp_slow <= exp_slow + 1;
      end else begin
        m_pre <= m_pre + 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       rd_seen = 1'b0;

  always @(posedge clk) rd_seen <= rd_stb;

  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) check(1'b0, "scoreboard-empty", rd_data, 0);
      else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(rd_data == e, t, rd_data, e);
      end
    end
  end

  // interrupt monitor: R7, R8
  always @(negedge clk) begin
    if (irq_fast) begin
      got_fast++;
      check(m_cnt[6:0] == 7'h00, "R7 fast pulse position", m_cnt, 0);
    end
    if (irq_slow) begin
      got_slow++;
      check(m_cnt[9:0] == 10'h000, "R8 slow pulse position", m_cnt, 0);
    end
  end

  task automatic rd(input logic [7:0] a, input string tag);
    @(negedge clk);
    if (a == 8'h24) begin
      exp_q.push_back(m_cnt[7:0]);
      m_shadow = m_cnt[11:8];
    end else if (a == 8'h25) exp_q.push_back({4'h0, m_shadow});
    else                     exp_q.push_back(8'h00);
    tag_q.push_back(tag);
    rd_stb  = 1'b1;
    rd_addr = a;
    @(negedge clk);
    rd_stb = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #400000;
    check(1'b0, "watchdog", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tick_en = 1'b0; rd_stb = 1'b0; rd_addr = 8'h00;
    idle(5);
    check(irq_fast == 1'b0 && irq_slow == 1'b0, "R1 irq idle in reset", {irq_slow, irq_fast}, 0);
    check(rd_data == 8'h00, "R1 rd_data in reset", rd_data, 0);
    rst_n = 1'b1;
    idle(4);
    rd(8'h24, "R1 low byte after reset");
    rd(8'h25, "R1 high byte after reset");

    tick_en = 1'b1;
    idle(300);
    rd(8'h24, "R4 R2 low byte");
    rd(8'h25, "R5 high byte");

    // R6: counter crosses a nibble boundary between the two reads
    rd(8'h24, "R4 low before gap");
    idle(1500);
    rd(8'h25, "R6 held nibble after gap");
    rd(8'h25, "R6 repeated high read");
    rd(8'h24, "R4 fresh low");
    rd(8'h25, "R5 fresh high");

    // R3: pause
    tick_en = 1'b0;
    rd(8'h24, "R3 low at pause");
    idle(50);
    rd(8'h24, "R3 low after pause");
    rd(8'h25, "R3 high after pause");
    tick_en = 1'b1;
    idle(7);
    rd(8'h24, "R2 low after resume");

    // R10: other addresses and idle strobe
    rd(8'h30, "R10 unmapped 0x30");
    rd(8'h24, "R10 low before idle sweep");
    idle(3);
    for (int i = 0; i < 10; i++) begin
      logic [7:0] held;
      held = rd_data;
      rd_addr = 8'h25 - i[7:0];
      @(negedge clk);
      check(rd_data == held, "R10 no strobe keeps data", rd_data, held);
    end
    rd(8'h25, "R10 holding kept through idle sweep");
    rd(8'h00, "R10 unmapped 0x00");

    // R9: wrap
    while (m_cnt != 12'hFFE) @(negedge clk);
    rd(8'h24, "R9 low near top");
    rd(8'h25, "R9 high near top");
    idle(2);
    rd(8'h24, "R9 low after wrap");
    rd(8'h25, "R9 high after wrap");
    idle(300);
    rd(8'h24, "R9 low counting on");

    idle(5);
    check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    check(got_fast == exp_fast, "R7 fast pulse count", got_fast, exp_fast);
    check(got_slow == exp_slow, "R8 slow pulse count", got_slow, exp_slow);
    check(exp_slow >= 4, "R8 slow pulses seen", exp_slow, 4);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule